// File: doc/BRIEF.md
# Critical-Word-First Line Fill

This block refills one cache line after a read miss. It accepts the missing byte address and breaks the line into chunks that match the width of the memory data bus. It then requests those chunks one beat at a time. The first request is for the chunk that holds the missing word. Later requests walk forward through the line and wrap back to the start of the line after the last chunk.

The beat that carries the missing word is forwarded to the core in the very next cycle, so the core can resume while the rest of the line is still arriving. Every beat is also stored in a fill buffer, in the slot that matches its position in the line. When the last beat has arrived, the whole line goes to the cache data array in a single write, together with its line-aligned address. Only one fill can be in flight at a time, and `busy` refuses new misses until that line write is done.

Top module: `cwf_line_fill`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy`, `mem_req`, `core_valid` and `line_we` are all 0.
- R2: In the cycle after a miss is accepted (`miss_valid` high while `busy` is low), `mem_req` is 1. `mem_addr` equals the miss address with its low 3 bits cleared, which is the 8-byte chunk that holds the miss.
- R3: Chunk k of a fill (k = 0..3) is requested at line base + 8·((c + k) mod 4), where c = miss address bits [4:3] and line base = miss address with bits [4:0] cleared. For a miss at 0x95 the order is 0x90, 0x98, 0x80, 0x88.
- R4: A beat ends only in a cycle with `mem_rvalid` high. Until then `mem_req` stays 1 and `mem_addr` holds its value. The next chunk address appears in the cycle after `mem_rvalid`.
- R5: `core_valid` is high for exactly one cycle, the cycle after the first beat's `mem_rvalid`. In that cycle `core_data` is the 32-bit word of the first beat chosen by miss address bit 2: 0 gives bits [31:0] and 1 gives bits [63:32].
- R6: `line_we` is high for exactly one cycle, the cycle after the fourth beat's `mem_rvalid`. In that cycle `line_addr` is the line base, and `line_data[64i+63:64i]` holds the beat read from line base + 8i.
- R7: `busy` is 1 from the cycle after acceptance through the `line_we` cycle, and 0 in the cycle after that. A `miss_valid` raised while `busy` is 1 is ignored: it does not change `mem_addr`, and no fill follows it.
- R8: Each fill produces exactly one `core_valid` pulse, and that pulse comes before its `line_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A read miss is presented |
| miss_addr | input | 32 | Byte address of the missing word |
| busy | output | 1 | A fill is in progress; new misses are refused |
| mem_req | output | 1 | A beat request is pending on the memory bus |
| mem_addr | output | 32 | Byte address of the requested 8-byte chunk |
| mem_rvalid | input | 1 | Read data for the pending beat is on `mem_rdata` |
| mem_rdata | input | 64 | Beat data |
| core_valid | output | 1 | One-cycle pulse: critical word is ready |
| core_data | output | 32 | Critical word for the core |
| line_we | output | 1 | One-cycle line write strobe to the cache array |
| line_addr | output | 32 | Line-aligned address of the write |
| line_data | output | 256 | Full assembled line |

## Verification
The assertions check on every cycle that:
- a pending request holds its address until data arrives;
- requests appear only while busy;
- the first request of a fill points at the chunk of the accepted miss;
- the forward and write strobes are one-cycle pulses;
- the written address is line-aligned;
- busy cannot drop before the line write.

Only the bench scenarios can show the full wrap-around order, the placement of each beat in the assembled line, and the choice of the forwarded word. The sweep covers every chunk and word offset on several line bases, with varying gaps between beats. Only the bench can also show that a miss raised during a fill leaves no trace.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
   typedef enum logic [1:0] {
      FS_IDLE  = 2'd0,
      FS_FETCH = 2'd1,
      FS_WRITE = 2'd2
   } fill_state_e;

   function automatic int unsigned cwf_log2(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((32'd1 << r) < v) r++;
      return r;
   endfunction
endpackage

// File: rtl/cwf_beat_seq.sv
module cwf_beat_seq #(
   parameter int unsigned BEATS = 4,
   localparam int unsigned IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [IDX_W-1:0] crit_idx,
   input  logic             advance,
   output logic [IDX_W-1:0] cur_idx,
   output logic             first_beat,
   output logic             last_beat
);
   logic [IDX_W-1:0] count_q;
   logic [IDX_W-1:0] crit_q;

   if ((BEATS & (BEATS - 1)) != 0) begin : g_bad_beats
      $error("cwf_beat_seq: BEATS must be a power of two");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
         crit_q  <= '0;
      end else if (start) begin
         count_q <= '0;
         crit_q  <= crit_idx;
      end else if (advance) begin
         count_q <= count_q + 1'b1;
      end
   end

   // modulo wrap comes from the natural width of the index
   assign cur_idx    = crit_q + count_q;
   assign first_beat = (count_q == '0);
   assign last_beat  = (count_q == IDX_W'(BEATS - 1));

   p_count_steps_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !start && !last_beat) |=> (cur_idx == $past(cur_idx) + 1'b1));
endmodule

// File: rtl/cwf_fill_buf.sv
module cwf_fill_buf #(
   parameter int unsigned BEATS  = 4,
   parameter int unsigned BEAT_W = 64,
   localparam int unsigned IDX_W  = (BEATS > 1) ? $clog2(BEATS) : 1,
   localparam int unsigned LINE_W = BEATS * BEAT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [BEAT_W-1:0] wr_data,
   output logic [LINE_W-1:0] line
);
   for (genvar s = 0; s < BEATS; s++) begin : g_slot
      logic [BEAT_W-1:0] slot_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            slot_q <= '0;
         else if (wr_en && (wr_idx == IDX_W'(s)))
            slot_q <= wr_data;
      end
      assign line[s*BEAT_W +: BEAT_W] = slot_q;
   end
endmodule

// File: rtl/cwf_word_pick.sv
module cwf_word_pick #(
   parameter int unsigned BEAT_W = 64,
   parameter int unsigned WORD_W = 32,
   localparam int unsigned WPB    = BEAT_W / WORD_W,
   localparam int unsigned SEL_W  = (WPB > 1) ? $clog2(WPB) : 1
) (
   input  logic [BEAT_W-1:0] beat,
   input  logic [SEL_W-1:0]  sel,
   output logic [WORD_W-1:0] word
);
   if (BEAT_W % WORD_W != 0) begin : g_bad_word
      $error("cwf_word_pick: BEAT_W must be a multiple of WORD_W");
   end

   if (WPB == 1) begin : g_pass
      logic unused_sel;
      assign unused_sel = ^sel;
      assign word = beat;
   end else begin : g_mux
      logic [WORD_W-1:0] lanes [WPB];
      for (genvar w = 0; w < WPB; w++) begin : g_lane
         assign lanes[w] = beat[w*WORD_W +: WORD_W];
      end
      assign word = lanes[sel];
   end
endmodule

// File: rtl/cwf_line_fill.sv
module cwf_line_fill
   import cwf_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned BEAT_W     = 64,
   parameter int unsigned WORD_W     = 32,
   parameter int unsigned LINE_BYTES = 32,
   localparam int unsigned LINE_W     = LINE_BYTES * 8,
   localparam int unsigned BEATS      = LINE_W / BEAT_W,
   localparam int unsigned IDX_W      = (BEATS > 1) ? $clog2(BEATS) : 1,
   localparam int unsigned OFF_W      = $clog2(LINE_BYTES),
   localparam int unsigned BOFF_W     = $clog2(BEAT_W / 8),
   localparam int unsigned WOFF_W     = $clog2(WORD_W / 8),
   localparam int unsigned WPB        = BEAT_W / WORD_W,
   localparam int unsigned SEL_W      = (WPB > 1) ? $clog2(WPB) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_valid,
   input  logic [ADDR_W-1:0] miss_addr,
   output logic              busy,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [BEAT_W-1:0] mem_rdata,
   output logic              core_valid,
   output logic [WORD_W-1:0] core_data,
   output logic              line_we,
   output logic [ADDR_W-1:0] line_addr,
   output logic [LINE_W-1:0] line_data
);
   if (BEATS < 2 || (BEATS * BEAT_W) != LINE_W) begin : g_bad_line
      $error("cwf_line_fill: line must hold two or more whole beats");
   end
   if (OFF_W != IDX_W + BOFF_W) begin : g_bad_off
      $error("cwf_line_fill: line size and beat size must be powers of two");
   end
   if (WORD_W > BEAT_W) begin : g_bad_ww
      $error("cwf_line_fill: core word wider than bus beat");
   end

   fill_state_e       state_q;
   logic [ADDR_W-1:0] addr_q;
   logic              fwd_q;
   logic [WORD_W-1:0] fwd_data_q;

   logic              accept;
   logic              beat_done;
   logic [IDX_W-1:0]  cur_idx;
   logic              first_beat;
   logic              last_beat;
   logic [SEL_W-1:0]  word_sel;
   logic [WORD_W-1:0] picked;

   assign accept    = miss_valid && (state_q == FS_IDLE);
   assign beat_done = (state_q == FS_FETCH) && mem_rvalid;

   cwf_beat_seq #(.BEATS(BEATS)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (accept),
      .crit_idx   (miss_addr[BOFF_W +: IDX_W]),
      .advance    (beat_done),
      .cur_idx    (cur_idx),
      .first_beat (first_beat),
      .last_beat  (last_beat)
   );

   cwf_fill_buf #(.BEATS(BEATS), .BEAT_W(BEAT_W)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (beat_done),
      .wr_idx  (cur_idx),
      .wr_data (mem_rdata),
      .line    (line_data)
   );

   if (WPB > 1) begin : g_sel
      assign word_sel = addr_q[WOFF_W +: SEL_W];
   end else begin : g_nosel
      assign word_sel = '0;
   end

   cwf_word_pick #(.BEAT_W(BEAT_W), .WORD_W(WORD_W)) u_pick (
      .beat (mem_rdata),
      .sel  (word_sel),
      .word (picked)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= FS_IDLE;
         addr_q     <= '0;
         fwd_q      <= 1'b0;
         fwd_data_q <= '0;
      end else begin
         fwd_q <= 1'b0;
         unique case (state_q)
            FS_IDLE: begin
               if (accept) begin
                  addr_q  <= miss_addr;
                  state_q <= FS_FETCH;
               end
            end
            FS_FETCH: begin
               if (mem_rvalid) begin
                  if (first_beat) begin
                     fwd_q      <= 1'b1;
                     fwd_data_q <= picked;
                  end
                  if (last_beat) state_q <= FS_WRITE;
               end
            end
            FS_WRITE: state_q <= FS_IDLE;
            default:  state_q <= FS_IDLE;
         endcase
      end
   end

   assign busy       = (state_q != FS_IDLE);
   assign mem_req    = (state_q == FS_FETCH);
   assign mem_addr   = {addr_q[ADDR_W-1:OFF_W], cur_idx, {BOFF_W{1'b0}}};
   assign core_valid = fwd_q;
   assign core_data  = fwd_data_q;
   assign line_we    = (state_q == FS_WRITE);
   assign line_addr  = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

   p_first_chunk_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> (mem_addr[ADDR_W-1:BOFF_W] == $past(miss_addr[ADDR_W-1:BOFF_W])));
   p_hold_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));
   p_fwd_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      core_valid |=> !core_valid);
   p_write_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      line_we |=> !line_we);
   p_write_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
      line_we |-> (line_addr[OFF_W-1:0] == '0));
   p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !line_we) |=> busy);
   p_req_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);
   p_fwd_before_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      core_valid |-> (busy && !line_we));
endmodule

// File: tb/tb_cwf_line_fill.sv
module tb_cwf_line_fill;
   localparam int CLK_PERIOD = 10;

   logic         clk;
   logic         rst_n;
   logic         miss_valid;
   logic [31:0]  miss_addr;
   logic         busy;
   logic         mem_req;
   logic [31:0]  mem_addr;
   logic         mem_rvalid;
   logic [63:0]  mem_rdata;
   logic         core_valid;
   logic [31:0]  core_data;
   logic         line_we;
   logic [31:0]  line_addr;
   logic [255:0] line_data;

   int total = 0;
   int bad   = 0;
   int fwd_seen;

   cwf_line_fill dut (
      .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
      .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .core_valid(core_valid), .core_data(core_data),
      .line_we(line_we), .line_addr(line_addr), .line_data(line_data)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [63:0] beat_of(input logic [31:0] a);
      return {a * 32'h9E37_79B1, a ^ 32'h5A5A_1234};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [255:0] act,
                      input logic [255:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_fill(input logic [31:0] a, input int gap, input bit poke);
      logic [31:0]  base;
      logic [1:0]   c;
      logic [31:0]  exp_a;
      logic [255:0] exp_line;
      base = a & ~32'h1F;
      c    = a[4:3];
      fwd_seen = 0;
      @(negedge clk);
      chk(!busy, "R7 idle before fill", 256'(busy), 0);
      miss_valid = 1'b1;
      miss_addr  = a;
      @(negedge clk);
      miss_valid = 1'b0;
      chk(busy && mem_req, "R2 request after accept", 256'({busy, mem_req}), 3);
      chk(mem_addr == (a & ~32'h7), "R2 first chunk", 256'(mem_addr), 256'(a & ~32'h7));
      for (int k = 0; k < 4; k++) begin
         exp_a = base + 32'({2'(c + 2'(k)), 3'b000});
         for (int g = 0; g < gap; g++) begin
            if (poke && g == 0) begin
               miss_valid = 1'b1;
               miss_addr  = a ^ 32'h0000_1018;
            end
            @(negedge clk);
            miss_valid = 1'b0;
            if (core_valid) fwd_seen++;
            chk(mem_req && mem_addr == exp_a, "R4 hold while waiting (R7 poke ignored)",
                256'(mem_addr), 256'(exp_a));
         end
         chk(mem_addr == exp_a, "R3 wrap order", 256'(mem_addr), 256'(exp_a));
         mem_rvalid = 1'b1;
         mem_rdata  = beat_of(exp_a);
         @(negedge clk);
         mem_rvalid = 1'b0;
         mem_rdata  = '0;
         if (core_valid) fwd_seen++;
         if (k == 0) begin
            logic [63:0] b;
            logic [31:0] w;
            b = beat_of(exp_a);
            w = a[2] ? b[63:32] : b[31:0];
            chk(core_valid && core_data == w, "R5 critical word forwarded",
                256'(core_data), 256'(w));
         end else begin
            chk(!core_valid, "R5 single pulse", 256'(core_valid), 0);
         end
         if (k < 3) begin
            chk(!line_we, "R6 no early write", 256'(line_we), 0);
         end
      end
      exp_line = '0;
      for (int i = 0; i < 4; i++) exp_line[64*i +: 64] = beat_of(base + 32'(8*i));
      chk(line_we && busy, "R6 write strobe after last beat", 256'({line_we, busy}), 3);
      chk(line_addr == base, "R6 line address", 256'(line_addr), 256'(base));
      chk(line_data == exp_line, "R6 line contents", line_data, exp_line);
      @(negedge clk);
      if (core_valid) fwd_seen++;
      chk(!line_we && !busy && !mem_req, "R7 free after write",
          256'({line_we, busy, mem_req}), 0);
      chk(fwd_seen == 1, "R8 one forward per fill", 256'(fwd_seen), 1);
      @(negedge clk);
      chk(!mem_req && !busy, "R7 poked miss left no fill", 256'({mem_req, busy}), 0);
   endtask

   initial begin
      rst_n = 1'b0;
      miss_valid = 1'b0;
      miss_addr = '0;
      mem_rvalid = 1'b0;
      mem_rdata = '0;
      repeat (3) @(negedge clk);
      chk(!busy && !mem_req && !core_valid && !line_we, "R1 reset outputs",
          256'({busy, mem_req, core_valid, line_we}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !mem_req && !core_valid && !line_we, "R1 after reset",
          256'({busy, mem_req, core_valid, line_we}), 0);
      do_fill(32'h0000_0095, 1, 1'b0);
      for (int b = 0; b < 4; b++) begin
         logic [31:0] lb;
         case (b)
            0: lb = 32'h0000_0080;
            1: lb = 32'h0000_0000;
            2: lb = 32'hFFFF_FFE0;
            default: lb = 32'h1234_5660;
         endcase
         for (int o = 0; o < 32; o += 4) begin
            do_fill(lb + 32'(o) + 32'(b & 3), (o / 4 + b) % 3, ((o / 4) % 2) == 1);
         end
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule